// File: doc/BRIEF.md
# Staged Wide-Register Bus Loader

This block is a write-only interface that connects a microprocessor to two wide configuration words. It sits on an 8-bit multiplexed address/data bus. A strap input selects one of two bus styles. In one style, a high address-latch pulse carries the address and an active-low write strobe carries the data. In the other, a high address strobe carries the address and a high data strobe carries the data while the read/write line is low. In both styles a chip select qualifies the write. All bus pins are asynchronous to the block. They pass through a synchroniser into the system clock domain, and the block acts on each write when its strobe ends.

The bus is only one byte wide, so software first writes up to three staging bytes. It then writes any byte to one of two command addresses. That write copies all 24 staged bits at once into either the control word or the initialisation word, and raises a one-clock update flag for the word that changed. Downstream logic sees only the two committed words and their flags. After a commit the staging bytes keep their contents, so software can change one byte and commit again.

Top module: `staged_reg_loader`

## Requirements
- R1: While reset is high and in the first cycle after it, both committed words read zero and both update flags are low.
- R2: Writes to addresses 0, 1 and 2 (bits 2:0 of the address byte) load staging bytes that feed bits 7:0, 15:8 and 23:16 of a committed word. Staging writes alone leave both committed words and both flags unchanged.
- R3: A write to address 3 copies the 24 staged bits into the control word and pulses ctrl_updated. The initialisation word is left unchanged.
- R4: A write to address 4 copies the 24 staged bits into the initialisation word and pulses init_updated. The control word is left unchanged.
- R5: The data byte carried by a write to address 3 or 4 has no effect on the committed value.
- R6: Writes to addresses 5, 6 and 7 change neither the staging bytes nor the committed words, and raise no flag.
- R7: With moto_mode low, the address is taken while addr_strobe is high, and the write takes effect after wr_n returns high. The committed word and its flag appear within 4 clock cycles of that rising edge.
- R8: With moto_mode high, the address is taken while addr_strobe is high. The write takes effect after ds falls, if rw was low during the ds pulse; a ds pulse with rw high changes nothing. The result appears within 4 clock cycles.
- R9: A write strobe during which cs_n stays high changes no state.
- R10: Staging bytes keep their values after a commit, so a later commit without new staging writes delivers the same 24 bits.
- R11: Each commit raises exactly one update flag, high for exactly one clock cycle. The two flags are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| moto_mode | input | 1 | Bus style strap: 0 = latch/write-strobe style, 1 = address/data-strobe style |
| cs_n | input | 1 | Chip select, active low |
| addr_strobe | input | 1 | Address latch / address strobe, high while the address is on ad |
| wr_n | input | 1 | Active-low write strobe (moto_mode = 0) |
| ds | input | 1 | Active-high data strobe (moto_mode = 1) |
| rw | input | 1 | Read/write select, low for write (moto_mode = 1) |
| ad | input | 8 | Multiplexed address/data bus |
| ctrl_reg | output | 24 | Committed control word |
| init_reg | output | 24 | Committed initialisation word |
| ctrl_updated | output | 1 | One-cycle pulse when the control word is committed |
| init_updated | output | 1 | One-cycle pulse when the initialisation word is committed |

## Verification
A wrong staging byte stays hidden until the next commit. It then shows up as a wrong byte lane in the committed word, so every sweep step ends with a commit and a compare of both words a few cycles after the strobe edge. A decode fault, such as a reserved address reaching staging or a commit going to the wrong word, shows up as a wrong flag count or a changed word on the very next commit. A fault in the strobe edge detector or the chip-select gate shows up as a missing or extra flag within four cycles of the trailing edge.

// File: rtl/slr_pkg.sv
package slr_pkg;
  parameter int BYTE_W    = 8;
  parameter int STAGE_CNT = 3;
  parameter int ADDR_W    = 3;
  parameter int SYNC_LEN  = 2;

  localparam int WORD_W = BYTE_W * STAGE_CNT;

  // command addresses follow the staging addresses
  localparam logic [ADDR_W-1:0] CMD_CTRL = ADDR_W'(STAGE_CNT);
  localparam logic [ADDR_W-1:0] CMD_INIT = ADDR_W'(STAGE_CNT + 1);

  typedef enum logic [1:0] {
    ACT_NONE  = 2'd0,
    ACT_STAGE = 2'd1,
    ACT_CTRL  = 2'd2,
    ACT_INIT  = 2'd3
  } wr_action_e;

  function automatic wr_action_e classify(input logic [ADDR_W-1:0] a);
    if (a < ADDR_W'(STAGE_CNT)) return ACT_STAGE;
    if (a == CMD_CTRL)          return ACT_CTRL;
    if (a == CMD_INIT)          return ACT_INIT;
    return ACT_NONE;
  endfunction
endpackage

// File: rtl/slr_sync.sv
module slr_sync #(
  parameter int           W      = 1,
  parameter int           STAGES = 2,
  parameter logic [W-1:0] RST_V  = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] chain [STAGES];

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_flop
      always_ff @(posedge clk) begin
        if (rst) chain[g] <= RST_V;
        else if (g == 0) chain[g] <= d;
        else chain[g] <= chain[(g == 0) ? 0 : g - 1];
      end
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/slr_bus_decode.sv
module slr_bus_decode #(
  parameter int BYTE_W = 8,
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              moto_mode,
  input  logic              cs_n_s,
  input  logic              astb_s,
  input  logic              wr_n_s,
  input  logic              ds_s,
  input  logic              rw_s,
  input  logic [BYTE_W-1:0] ad_s,
  output logic              wr_valid,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [BYTE_W-1:0] wr_data
);
  logic              strobe;
  logic              strobe_q;
  logic              armed;
  logic [ADDR_W-1:0] addr_q;
  logic [BYTE_W-1:0] data_q;

  // data phase strobe for the selected bus style
  always_comb begin
    if (moto_mode) strobe = ds_s & ~rw_s;
    else           strobe = ~wr_n_s;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      addr_q   <= '0;
      data_q   <= '0;
      armed    <= 1'b0;
      strobe_q <= 1'b0;
      wr_valid <= 1'b0;
      wr_addr  <= '0;
      wr_data  <= '0;
    end else begin
      strobe_q <= strobe;
      if (astb_s) addr_q <= ad_s[ADDR_W-1:0];
      if (strobe && !cs_n_s) begin
        data_q <= ad_s;
        armed  <= 1'b1;
      end
      if (strobe_q && !strobe) begin
        wr_valid <= armed;
        wr_addr  <= addr_q;
        wr_data  <= data_q;
        armed    <= 1'b0;
      end else begin
        wr_valid <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/slr_stage_bank.sv
module slr_stage_bank #(
  parameter int BYTE_W    = 8,
  parameter int STAGE_CNT = 3,
  parameter int ADDR_W    = 3,
  localparam int WORD_W   = BYTE_W * STAGE_CNT
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_valid,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [BYTE_W-1:0] wr_data,
  output logic [WORD_W-1:0] staged
);
  genvar g;
  generate
    for (g = 0; g < STAGE_CNT; g++) begin : g_byte
      logic [BYTE_W-1:0] byte_q;
      always_ff @(posedge clk) begin
        if (rst) byte_q <= '0;
        else if (wr_valid && wr_addr == ADDR_W'(g)) byte_q <= wr_data;
      end
      assign staged[g*BYTE_W +: BYTE_W] = byte_q;
    end
  endgenerate
endmodule

// File: rtl/slr_commit.sv
module slr_commit #(
  parameter int WORD_W = 24,
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_valid,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [WORD_W-1:0] staged,
  output logic [WORD_W-1:0] ctrl_reg,
  output logic [WORD_W-1:0] init_reg,
  output logic              ctrl_updated,
  output logic              init_updated
);
  import slr_pkg::*;

  wr_action_e act;
  always_comb act = wr_valid ? classify(wr_addr) : ACT_NONE;

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_reg     <= '0;
      init_reg     <= '0;
      ctrl_updated <= 1'b0;
      init_updated <= 1'b0;
    end else begin
      ctrl_updated <= (act == ACT_CTRL);
      init_updated <= (act == ACT_INIT);
      if (act == ACT_CTRL) ctrl_reg <= staged;
      if (act == ACT_INIT) init_reg <= staged;
    end
  end
endmodule

// File: rtl/staged_reg_loader.sv
module staged_reg_loader #(
  parameter int BYTE_W    = slr_pkg::BYTE_W,
  parameter int STAGE_CNT = slr_pkg::STAGE_CNT,
  parameter int ADDR_W    = slr_pkg::ADDR_W,
  parameter int SYNC_LEN  = slr_pkg::SYNC_LEN,
  localparam int WORD_W   = BYTE_W * STAGE_CNT
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              moto_mode,
  input  logic              cs_n,
  input  logic              addr_strobe,
  input  logic              wr_n,
  input  logic              ds,
  input  logic              rw,
  input  logic [BYTE_W-1:0] ad,
  output logic [WORD_W-1:0] ctrl_reg,
  output logic [WORD_W-1:0] init_reg,
  output logic              ctrl_updated,
  output logic              init_updated
);
  localparam int BUNDLE_W = BYTE_W + 5;
  localparam logic [BUNDLE_W-1:0] BUNDLE_IDLE = {1'b1, 1'b0, 1'b1, 1'b0, 1'b1, {BYTE_W{1'b0}}};

  logic [BUNDLE_W-1:0] bus_raw, bus_s;
  logic                cs_n_s, astb_s, wr_n_s, ds_s, rw_s;
  logic [BYTE_W-1:0]   ad_s;
  logic                wr_valid;
  logic [ADDR_W-1:0]   wr_addr;
  logic [BYTE_W-1:0]   wr_data;
  logic [WORD_W-1:0]   staged;

  assign bus_raw = {cs_n, addr_strobe, wr_n, ds, rw, ad};
  assign {cs_n_s, astb_s, wr_n_s, ds_s, rw_s, ad_s} = bus_s;

  slr_sync #(.W(BUNDLE_W), .STAGES(SYNC_LEN), .RST_V(BUNDLE_IDLE)) u_sync (
    .clk(clk), .rst(rst), .d(bus_raw), .q(bus_s)
  );

  slr_bus_decode #(.BYTE_W(BYTE_W), .ADDR_W(ADDR_W)) u_dec (
    .clk(clk), .rst(rst), .moto_mode(moto_mode),
    .cs_n_s(cs_n_s), .astb_s(astb_s), .wr_n_s(wr_n_s), .ds_s(ds_s), .rw_s(rw_s),
    .ad_s(ad_s), .wr_valid(wr_valid), .wr_addr(wr_addr), .wr_data(wr_data)
  );

  slr_stage_bank #(.BYTE_W(BYTE_W), .STAGE_CNT(STAGE_CNT), .ADDR_W(ADDR_W)) u_stage (
    .clk(clk), .rst(rst), .wr_valid(wr_valid), .wr_addr(wr_addr),
    .wr_data(wr_data), .staged(staged)
  );

  slr_commit #(.WORD_W(WORD_W), .ADDR_W(ADDR_W)) u_commit (
    .clk(clk), .rst(rst), .wr_valid(wr_valid), .wr_addr(wr_addr), .staged(staged),
    .ctrl_reg(ctrl_reg), .init_reg(init_reg),
    .ctrl_updated(ctrl_updated), .init_updated(init_updated)
  );
endmodule

// File: rtl/slr_checker.sv
module slr_checker #(
  parameter int WORD_W = 24,
  parameter int ADDR_W = 3
) (
  input logic              clk,
  input logic              rst,
  input logic              wr_valid,
  input logic [ADDR_W-1:0] wr_addr,
  input logic [WORD_W-1:0] staged,
  input logic [WORD_W-1:0] ctrl_reg,
  input logic [WORD_W-1:0] init_reg,
  input logic              ctrl_updated,
  input logic              init_updated
);
  // R1
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (ctrl_reg == '0 && init_reg == '0 && !ctrl_updated && !init_updated));

  // R11
  flags_exclusive_chk: assert property (@(posedge clk) disable iff (rst)
    !(ctrl_updated && init_updated));

  // R11
  ctrl_pulse_width_chk: assert property (@(posedge clk) disable iff (rst)
    ctrl_updated |=> !ctrl_updated);

  // R11
  init_pulse_width_chk: assert property (@(posedge clk) disable iff (rst)
    init_updated |=> !init_updated);

  // R3
  ctrl_holds_chk: assert property (@(posedge clk) disable iff (rst)
    !ctrl_updated |-> $stable(ctrl_reg));

  // R4
  init_holds_chk: assert property (@(posedge clk) disable iff (rst)
    !init_updated |-> $stable(init_reg));

  // R3
  ctrl_gets_staged_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_valid && wr_addr == ADDR_W'(3)) |=> (ctrl_updated && ctrl_reg == $past(staged)));

  // R4
  init_gets_staged_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_valid && wr_addr == ADDR_W'(4)) |=> (init_updated && init_reg == $past(staged)));

  // R6
  reserved_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_valid && wr_addr > ADDR_W'(4)) |=> (!ctrl_updated && !init_updated && $stable(staged)));
endmodule

bind staged_reg_loader slr_checker #(.WORD_W(WORD_W), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst(rst), .wr_valid(wr_valid), .wr_addr(wr_addr), .staged(staged),
  .ctrl_reg(ctrl_reg), .init_reg(init_reg),
  .ctrl_updated(ctrl_updated), .init_updated(init_updated)
);

// File: tb/sim_staged_reg_loader.sv
module sim_staged_reg_loader;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        moto_mode = 1'b0;
  logic        cs_n = 1'b1;
  logic        addr_strobe = 1'b0;
  logic        wr_n = 1'b1;
  logic        ds = 1'b0;
  logic        rw = 1'b1;
  logic [7:0]  ad = 8'h00;
  logic [23:0] ctrl_reg, init_reg;
  logic        ctrl_updated, init_updated;

  int vectors = 0;
  int errors  = 0;
  int ctrl_pulses = 0;
  int init_pulses = 0;
  int both_high = 0;
  int long_pulse = 0;
  logic ctrl_prev = 1'b0, init_prev = 1'b0;

  logic [7:0]  exp_stage [3];
  logic [23:0] exp_ctrl = '0, exp_init = '0;
  int          exp_cp = 0, exp_ip = 0;

  always #10 clk = ~clk;

  staged_reg_loader u0 (
    .clk(clk), .rst(rst), .moto_mode(moto_mode), .cs_n(cs_n),
    .addr_strobe(addr_strobe), .wr_n(wr_n), .ds(ds), .rw(rw), .ad(ad),
    .ctrl_reg(ctrl_reg), .init_reg(init_reg),
    .ctrl_updated(ctrl_updated), .init_updated(init_updated)
  );

  // observe flags at the ports
  always @(negedge clk) begin
    if (!rst) begin
      if (ctrl_updated) ctrl_pulses++;
      if (init_updated) init_pulses++;
      if (ctrl_updated && init_updated) both_high++;
      if ((ctrl_updated && ctrl_prev) || (init_updated && init_prev)) long_pulse++;
    end
    ctrl_prev = ctrl_updated;
    init_prev = init_updated;
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic check_all(input string tag);
    check({tag, " ctrl_reg"}, {8'h0, ctrl_reg}, {8'h0, exp_ctrl});
    check({tag, " init_reg"}, {8'h0, init_reg}, {8'h0, exp_init});
    check({tag, " ctrl flags"}, ctrl_pulses, exp_cp);
    check({tag, " init flags"}, init_pulses, exp_ip);
  endtask

  // one bus write; sel=0 leaves cs_n high, rw_v only matters in moto_mode
  task automatic bus_write(input logic [2:0] a, input logic [7:0] d,
                           input logic sel, input logic rw_v);
    @(negedge clk);
    ad = {5'b0, a};
    addr_strobe = 1'b1;
    repeat (3) @(negedge clk);
    addr_strobe = 1'b0;
    repeat (2) @(negedge clk);
    ad = d;
    cs_n = ~sel;
    if (moto_mode) begin rw = rw_v; ds = 1'b1; end
    else wr_n = 1'b0;
    repeat (3) @(negedge clk);
    if (moto_mode) ds = 1'b0;
    else wr_n = 1'b1;
    // trailing edge; result due within 4 clocks
    repeat (5) @(negedge clk);
    cs_n = 1'b1;
    rw = 1'b1;
    if (sel && (!moto_mode || !rw_v)) begin
      if (a < 3) exp_stage[a] = d;
      else if (a == 3) begin exp_ctrl = {exp_stage[2], exp_stage[1], exp_stage[0]}; exp_cp++; end
      else if (a == 4) begin exp_init = {exp_stage[2], exp_stage[1], exp_stage[0]}; exp_ip++; end
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    for (int k = 0; k < 3; k++) exp_stage[k] = 8'h00;
    repeat (4) @(negedge clk);
    // R1 reset state
    check("R1 ctrl reset", {8'h0, ctrl_reg}, 32'h0);
    check("R1 init reset", {8'h0, init_reg}, 32'h0);
    check("R1 flags reset", {30'h0, ctrl_updated, init_updated}, 32'h0);
    rst = 1'b0;
    @(negedge clk);
    check("R1 after release", {8'h0, ctrl_reg ^ init_reg}, 32'h0);

    for (int m = 0; m < 2; m++) begin
      moto_mode = m[0];
      repeat (4) @(negedge clk);
      for (int i = 0; i < 12; i++) begin
        for (int k = 0; k < 3; k++)
          bus_write(3'(k), 8'((i * 37 + k * 91 + m * 13 + 5) & 8'hFF), 1'b1, 1'b0);
        check_all("R2 staged only");
        // R5: commit data byte varies and must not matter
        bus_write((i % 2 == 0) ? 3'd3 : 3'd4, 8'((i * 53) ^ 8'hA5), 1'b1, 1'b0);
        check_all((i % 2 == 0) ? "R3 R5 ctrl commit" : "R4 R5 init commit");
      end
      // R6 reserved addresses, then commit to prove staging untouched
      for (int a = 5; a < 8; a++) bus_write(3'(a), 8'hEE, 1'b1, 1'b0);
      check_all("R6 reserved no effect");
      bus_write(3'd3, 8'h00, 1'b1, 1'b0);
      check_all("R6 staging intact");
      // R9 write without chip select
      bus_write(3'd1, 8'h5A, 1'b0, 1'b0);
      bus_write(3'd4, 8'h00, 1'b0, 1'b0);
      check_all("R9 deselected");
      bus_write(3'd4, 8'h00, 1'b1, 1'b0);
      check_all("R9 staging intact");
      // R10 partial reuse after commit
      bus_write(3'd2, 8'(8'hC3 + m), 1'b1, 1'b0);
      bus_write(3'd3, 8'hFF, 1'b1, 1'b0);
      bus_write(3'd4, 8'h11, 1'b1, 1'b0);
      check_all("R10 reuse");
      check("R10 both words equal", {8'h0, ctrl_reg}, {8'h0, init_reg});
      if (m == 1) begin
        // R8 read cycle ignored
        bus_write(3'd0, 8'h77, 1'b1, 1'b1);
        bus_write(3'd3, 8'h00, 1'b1, 1'b1);
        check_all("R8 read cycle ignored");
        bus_write(3'd3, 8'h00, 1'b1, 1'b0);
        check_all("R8 moto commit");
      end else begin
        check_all("R7 intel mode");
      end
    end

    // R11 flag shape
    check("R11 both flags high", both_high, 0);
    check("R11 pulse longer than one", long_pulse, 0);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule